// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit with Flag Byte

This block performs the arithmetic and logic step of an 8-bit accumulator machine. Each request carries an operation code, two operands and the current flag byte. The block returns the result and the next flag byte. Each operation rewrites only its own set of flags and copies the rest from the incoming byte. The 8-bit set covers add, subtract with and without carry, compare, the three bitwise operations, increment, decrement, negate, complement, packed-BCD decimal adjust, and the two carry-flag operations. A 16-bit side path adds to a register pair, and adds or subtracts with carry, under its own flag rules.

Requests enter on a valid/ready stream and results leave on a second valid/ready stream, through a single register stage. The input is ready whenever the output register is empty or is being drained in the same cycle. A result that is not taken stays on the output, unchanged, until it is. An accepted request always produces exactly one result, one cycle later.

Top module: `acc_alu`

## Requirements
- R1: A request is accepted on a rising edge where `in_valid` and `in_ready` are both 1. Its result shows `out_valid`=1 after that same edge. `in_ready` equals `!out_valid || out_ready`. While `out_valid`=1 and `out_ready`=0, the result and flags on the output do not change.
- R2: Flag byte positions are: sign bit 7, zero bit 6, half carry bit 4, parity/overflow bit 2, subtract marker bit 1, carry bit 0. Bits 5 and 3 are always copied from `in_flags`. The operation codes are: 0 add, 1 add with carry, 2 subtract, 3 subtract with carry, 4 compare, 5 and, 6 or, 7 xor, 8 increment, 9 decrement, 10 negate, 11 complement, 12 decimal adjust, 13 set carry, 14 complement carry, 15 word add, 16 word add with carry, 17 word subtract with carry. Codes 18 to 31 return `in_a` unchanged, with the flags unchanged. 8-bit operations work on the low bytes of the operands and return zero in `out_result[15:8]`.
- R3: Add and add-with-carry return a+b(+C). They set S and Z from the result. H is the carry out of bit 3, P/V is signed overflow, N is 0 and C is the carry out of bit 7.
- R4: Subtract and subtract-with-carry return a-b(-C), and negate returns 0-a. All three set N=1. H is the borrow into bit 4, P/V is signed overflow, C is the borrow, and S and Z come from the result.
- R5: Compare sets its flags exactly as subtract does, but returns the accumulator `in_a[7:0]` unchanged.
- R6: And, or and xor set S and Z from the result and P/V=1 when the result has an even number of ones. N and C are forced to 0. H is 1 for and and 0 for the other two.
- R7: Increment and decrement add or subtract 1. They update S, Z, H and P/V (overflow) and leave C unchanged. N is 0 for increment and 1 for decrement.
- R8: Complement returns ~a and sets H=1 and N=1, with the other flags unchanged. Set-carry returns a and sets C=1, H=0 and N=0. Complement-carry returns a, inverts C, sets N=0 and copies the old C into H.
- R9: Decimal adjust applies a correction to a. The correction includes 0x06 when H=1 or the low nibble is above 9. It includes 0x60 when C=1 or a is above 0x99, and in that case the new C is 1; otherwise C is kept. The correction is added when N=0 and subtracted when N=1. H becomes (low nibble > 9) when N=0, and (old H and low nibble < 6) when N=1. S, Z and parity come from the result, and N is kept.
- R10: Word add returns the 16-bit sum. H is the carry out of bit 11, N is 0 and C is the carry out of bit 15. S, Z and P/V are unchanged.
- R11: Word add with carry and word subtract with carry return a±b±C on 16 bits. They set S from bit 15 and Z from all 16 bits. P/V is signed overflow, H is the carry or borrow at bit 11, and C is the carry or borrow out of bit 15. N is 0 for add and 1 for subtract.
- R12: During and after reset, `out_valid`=0, `in_ready`=1, and `out_result` and `out_flags` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_op | input | 5 | Operation code |
| in_a | input | 16 | First operand (accumulator in low byte) |
| in_b | input | 16 | Second operand |
| in_flags | input | 8 | Flag byte before the operation |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 16 | Result value |
| out_flags | output | 8 | Flag byte after the operation |

## Verification
The only state in the block is the output register and its valid bit, so any fault shows on the very next result. A corrupted result or flag byte appears on the first request after the fault. A lost valid bit either drops a result or leaves `in_ready` low during a stall. A faulty stall path changes the output while it is held. Flag faults tend to hide in rarely reached bits: the bit-3 and bit-11 carries, overflow at 0x7F/0x80, and both decimal-adjust corrections. Directed corner cases therefore sit alongside a long random run that compares every result and flag byte against a model written from the requirements.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int OP_W   = 5;
  localparam int NIB_W  = BYTE_W / 2;

  localparam int FL_S = 7;
  localparam int FL_Z = 6;
  localparam int FL_H = 4;
  localparam int FL_P = 2;
  localparam int FL_N = 1;
  localparam int FL_C = 0;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 5'd0,  OP_ADC  = 5'd1,  OP_SUB  = 5'd2,  OP_SBC  = 5'd3,
    OP_CMP  = 5'd4,  OP_AND  = 5'd5,  OP_OR   = 5'd6,  OP_XOR  = 5'd7,
    OP_INC  = 5'd8,  OP_DEC  = 5'd9,  OP_NEG  = 5'd10, OP_CPL  = 5'd11,
    OP_DAA  = 5'd12, OP_SCF  = 5'd13, OP_CCF  = 5'd14, OP_ADDW = 5'd15,
    OP_ADCW = 5'd16, OP_SBCW = 5'd17
  } alu_op_e;

  typedef struct packed {
    logic [WORD_W-1:0] value;
    logic [BYTE_W-1:0] flags;
  } alu_out_t;
endpackage

// File: rtl/acc_alu_byte.sv
module acc_alu_byte
  import acc_alu_pkg::*;
(
  input  alu_op_e           op,
  input  logic [BYTE_W-1:0] a,
  input  logic [BYTE_W-1:0] b,
  input  logic [BYTE_W-1:0] fin,
  output logic [BYTE_W-1:0] res,
  output logic [BYTE_W-1:0] fout
);
  localparam int MSB = BYTE_W - 1;

  logic [BYTE_W-1:0] x, y;
  logic              ci;
  logic [BYTE_W:0]   sum_w, dif_w;
  logic [NIB_W:0]    sum_n, dif_n;
  logic              add_ov, sub_ov;

  always_comb begin
    x  = a;
    y  = b;
    ci = 1'b0;
    case (op)
      OP_ADC, OP_SBC: ci = fin[FL_C];
      OP_INC, OP_DEC: y  = BYTE_W'(1);
      OP_NEG: begin
        x = '0;
        y = a;
      end
      default: ;
    endcase
  end

  assign sum_w  = {1'b0, x} + {1'b0, y} + {{BYTE_W{1'b0}}, ci};
  assign dif_w  = {1'b0, x} - {1'b0, y} - {{BYTE_W{1'b0}}, ci};
  assign sum_n  = {1'b0, x[NIB_W-1:0]} + {1'b0, y[NIB_W-1:0]} + {{NIB_W{1'b0}}, ci};
  assign dif_n  = {1'b0, x[NIB_W-1:0]} - {1'b0, y[NIB_W-1:0]} - {{NIB_W{1'b0}}, ci};
  assign add_ov = (x[MSB] == y[MSB]) && (sum_w[MSB] != x[MSB]);
  assign sub_ov = (x[MSB] != y[MSB]) && (dif_w[MSB] != x[MSB]);

  always_comb begin
    res  = a;
    fout = fin;
    case (op)
      OP_ADD, OP_ADC, OP_INC: begin
        res        = sum_w[MSB:0];
        fout[FL_H] = sum_n[NIB_W];
        fout[FL_P] = add_ov;
        fout[FL_N] = 1'b0;
        if (op != OP_INC) fout[FL_C] = sum_w[BYTE_W];
      end
      OP_SUB, OP_SBC, OP_CMP, OP_DEC, OP_NEG: begin
        res        = (op == OP_CMP) ? a : dif_w[MSB:0];
        fout[FL_H] = dif_n[NIB_W];
        fout[FL_P] = sub_ov;
        fout[FL_N] = 1'b1;
        if (op != OP_DEC) fout[FL_C] = dif_w[BYTE_W];
      end
      OP_AND, OP_OR, OP_XOR: begin
        res        = (op == OP_AND) ? (a & b) : (op == OP_OR) ? (a | b) : (a ^ b);
        fout[FL_H] = (op == OP_AND);
        fout[FL_P] = ~^res;
        fout[FL_N] = 1'b0;
        fout[FL_C] = 1'b0;
      end
      OP_CPL: begin
        res        = ~a;
        fout[FL_H] = 1'b1;
        fout[FL_N] = 1'b1;
      end
      OP_SCF: begin
        fout[FL_C] = 1'b1;
        fout[FL_H] = 1'b0;
        fout[FL_N] = 1'b0;
      end
      OP_CCF: begin
        fout[FL_C] = ~fin[FL_C];
        fout[FL_H] = fin[FL_C];
        fout[FL_N] = 1'b0;
      end
      default: ;
    endcase
    case (op)
      OP_CPL, OP_SCF, OP_CCF: ;
      default: begin
        fout[FL_S] = (op == OP_CMP) ? dif_w[MSB] : res[MSB];
        fout[FL_Z] = (op == OP_CMP) ? (dif_w[MSB:0] == '0) : (res == '0);
      end
    endcase
  end
endmodule

// File: rtl/acc_alu_bcd.sv
module acc_alu_bcd
  import acc_alu_pkg::*;
(
  input  logic [BYTE_W-1:0] a,
  input  logic [BYTE_W-1:0] fin,
  output logic [BYTE_W-1:0] res,
  output logic [BYTE_W-1:0] fout
);
  localparam logic [BYTE_W-1:0] LO_FIX = BYTE_W'(6);
  localparam logic [BYTE_W-1:0] HI_FIX = BYTE_W'(8'h60);
  localparam logic [NIB_W-1:0]  NIB_MAX = NIB_W'(9);

  logic [NIB_W-1:0]  lo;
  logic              need_lo, need_hi;
  logic [BYTE_W-1:0] corr;

  assign lo      = a[NIB_W-1:0];
  assign need_lo = fin[FL_H] || (lo > NIB_MAX);
  assign need_hi = fin[FL_C] || (a > BYTE_W'(8'h99));
  assign corr    = (need_lo ? LO_FIX : '0) | (need_hi ? HI_FIX : '0);

  always_comb begin
    fout       = fin;
    res        = fin[FL_N] ? (a - corr) : (a + corr);
    fout[FL_C] = fin[FL_C] | need_hi;
    fout[FL_H] = fin[FL_N] ? (fin[FL_H] && (lo < NIB_W'(6))) : (lo > NIB_MAX);
    fout[FL_S] = res[BYTE_W-1];
    fout[FL_Z] = (res == '0);
    fout[FL_P] = ~^res;
  end
endmodule

// File: rtl/acc_alu_word.sv
module acc_alu_word
  import acc_alu_pkg::*;
(
  input  alu_op_e           op,
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  input  logic [BYTE_W-1:0] fin,
  output logic [WORD_W-1:0] res,
  output logic [BYTE_W-1:0] fout
);
  localparam int MSB   = WORD_W - 1;
  localparam int LOW_W = WORD_W - NIB_W;

  logic            ci;
  logic [WORD_W:0] sum_w, dif_w;
  logic [LOW_W:0]  sum_l, dif_l;

  assign ci    = (op == OP_ADDW) ? 1'b0 : fin[FL_C];
  assign sum_w = {1'b0, a} + {1'b0, b} + {{WORD_W{1'b0}}, ci};
  assign dif_w = {1'b0, a} - {1'b0, b} - {{WORD_W{1'b0}}, ci};
  assign sum_l = {1'b0, a[LOW_W-1:0]} + {1'b0, b[LOW_W-1:0]} + {{LOW_W{1'b0}}, ci};
  assign dif_l = {1'b0, a[LOW_W-1:0]} - {1'b0, b[LOW_W-1:0]} - {{LOW_W{1'b0}}, ci};

  always_comb begin
    fout = fin;
    if (op == OP_SBCW) begin
      res        = dif_w[MSB:0];
      fout[FL_H] = dif_l[LOW_W];
      fout[FL_C] = dif_w[WORD_W];
      fout[FL_N] = 1'b1;
      fout[FL_P] = (a[MSB] != b[MSB]) && (dif_w[MSB] != a[MSB]);
    end else begin
      res        = sum_w[MSB:0];
      fout[FL_H] = sum_l[LOW_W];
      fout[FL_C] = sum_w[WORD_W];
      fout[FL_N] = 1'b0;
      fout[FL_P] = (a[MSB] == b[MSB]) && (sum_w[MSB] != a[MSB]);
    end
    if (op == OP_ADDW) begin
      fout[FL_P] = fin[FL_P];
    end else begin
      fout[FL_S] = res[MSB];
      fout[FL_Z] = (res == '0);
    end
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OP_W-1:0]   in_op,
  input  logic [WORD_W-1:0] in_a,
  input  logic [WORD_W-1:0] in_b,
  input  logic [BYTE_W-1:0] in_flags,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_result,
  output logic [BYTE_W-1:0] out_flags
);
  alu_op_e           op;
  logic [BYTE_W-1:0] byte_res, byte_fl, bcd_res, bcd_fl, word_fl;
  logic [WORD_W-1:0] word_res;
  alu_out_t          nxt, held;
  logic              take;

  assign op = alu_op_e'(in_op);

  acc_alu_byte u_byte (
    .op(op), .a(in_a[BYTE_W-1:0]), .b(in_b[BYTE_W-1:0]), .fin(in_flags),
    .res(byte_res), .fout(byte_fl)
  );

  acc_alu_bcd u_bcd (
    .a(in_a[BYTE_W-1:0]), .fin(in_flags), .res(bcd_res), .fout(bcd_fl)
  );

  acc_alu_word u_word (
    .op(op), .a(in_a), .b(in_b), .fin(in_flags), .res(word_res), .fout(word_fl)
  );

  always_comb begin
    case (op)
      OP_DAA: nxt = '{value: {{BYTE_W{1'b0}}, bcd_res}, flags: bcd_fl};
      OP_ADDW, OP_ADCW, OP_SBCW: nxt = '{value: word_res, flags: word_fl};
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP, OP_AND, OP_OR, OP_XOR,
      OP_INC, OP_DEC, OP_NEG, OP_CPL, OP_SCF, OP_CCF:
        nxt = '{value: {{BYTE_W{1'b0}}, byte_res}, flags: byte_fl};
      default: nxt = '{value: in_a, flags: in_flags};
    endcase
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      held      <= '0;
    end else begin
      if (take) begin
        held      <= nxt;
        out_valid <= 1'b1;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  assign out_result = held.value;
  assign out_flags  = held.flags;

  a_r1_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_flags)));

  a_r1_accept_gives_result: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  a_r2_spare_bits_copied: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_flags[5] == $past(in_flags[5]) && out_flags[3] == $past(in_flags[3])));

  a_r5_compare_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op == OP_CMP) |=> out_result == {{BYTE_W{1'b0}}, $past(in_a[BYTE_W-1:0])});

  a_r6_logic_clears_n_c: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (in_op == OP_AND || in_op == OP_OR || in_op == OP_XOR))
      |=> (!out_flags[FL_N] && !out_flags[FL_C]));

  a_r10_word_add_keeps_szp: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op == OP_ADDW)
      |=> (out_flags[FL_S] == $past(in_flags[FL_S]) && out_flags[FL_Z] == $past(in_flags[FL_Z])
           && out_flags[FL_P] == $past(in_flags[FL_P]) && !out_flags[FL_N]));
endmodule

// File: tb/acc_alu_tb.sv
module acc_alu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [4:0]  in_op = '0;
  logic [15:0] in_a = '0, in_b = '0;
  logic [7:0]  in_flags = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_result;
  logic [7:0]  out_flags;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  acc_alu u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_flags(in_flags),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_flags(out_flags)
  );

  always #4 clk = ~clk;

  function automatic logic [7:0] mkfl(input logic [7:0] f, input bit s, z, h, p, n, c);
    return {s, z, f[5], h, f[3], p, n, c};
  endfunction

  function automatic string tag_of(input int op);
    case (op)
      0, 1:       return "R3";
      2, 3, 10:   return "R4";
      4:          return "R5";
      5, 6, 7:    return "R6";
      8, 9:       return "R7";
      11, 13, 14: return "R8";
      12:         return "R9";
      15:         return "R10";
      16, 17:     return "R11";
      default:    return "R2";
    endcase
  endfunction

  // expected {result, flags} computed from the requirements
  function automatic logic [23:0] model(input int op, input logic [15:0] a, b, input logic [7:0] f);
    int x, y, s, ci, lo, corr, hs;
    bit h, v, c;
    logic [7:0] r;
    logic [15:0] w;
    x = int'(a[7:0]); y = int'(b[7:0]); c = f[0];
    case (op)
      0, 1, 8: begin
        ci = (op == 1) ? int'(c) : 0;
        if (op == 8) y = 1;
        s = x + y + ci; r = s[7:0];
        h = ((x % 16) + (y % 16) + ci) > 15;
        v = (((x ^ s) & (y ^ s)) & 128) != 0;
        return {8'h00, r, mkfl(f, r[7], r == 0, h, v, 1'b0, (op == 8) ? c : (s > 255))};
      end
      2, 3, 4, 9, 10: begin
        ci = (op == 3) ? int'(c) : 0;
        if (op == 9) y = 1;
        if (op == 10) begin y = x; x = 0; end
        s = x - y - ci; r = s[7:0];
        h = ((x % 16) - (y % 16) - ci) < 0;
        v = (((x ^ y) & (x ^ s)) & 128) != 0;
        return {8'h00, (op == 4) ? a[7:0] : r,
                mkfl(f, r[7], r == 0, h, v, 1'b1, (op == 9) ? c : (s < 0))};
      end
      5, 6, 7: begin
        r = (op == 5) ? (a[7:0] & b[7:0]) : (op == 6) ? (a[7:0] | b[7:0]) : (a[7:0] ^ b[7:0]);
        return {8'h00, r, mkfl(f, r[7], r == 0, op == 5, ($countones(r) % 2) == 0, 1'b0, 1'b0)};
      end
      11: return {8'h00, ~a[7:0], mkfl(f, f[7], f[6], 1'b1, f[2], 1'b1, f[0])};
      13: return {8'h00, a[7:0], mkfl(f, f[7], f[6], 1'b0, f[2], 1'b0, 1'b1)};
      14: return {8'h00, a[7:0], mkfl(f, f[7], f[6], f[0], f[2], 1'b0, !f[0])};
      12: begin
        lo = x % 16; corr = 0;
        if (f[4] || lo > 9) corr += 6;
        if (f[0] || x > 153) begin corr += 96; c = 1'b1; end
        s = f[1] ? (x - corr) : (x + corr); r = s[7:0];
        h = f[1] ? (f[4] && lo < 6) : (lo > 9);
        return {8'h00, r, mkfl(f, r[7], r == 0, h, ($countones(r) % 2) == 0, f[1], c)};
      end
      15, 16, 17: begin
        x = int'(a); y = int'(b);
        ci = (op == 15) ? 0 : int'(c);
        if (op == 17) begin
          s = x - y - ci; hs = (x % 4096) - (y % 4096) - ci;
          h = hs < 0; c = s < 0;
          v = (((x ^ y) & (x ^ s)) & 32768) != 0;
        end else begin
          s = x + y + ci; hs = (x % 4096) + (y % 4096) + ci;
          h = hs > 4095; c = s > 65535;
          v = (((x ^ s) & (y ^ s)) & 32768) != 0;
        end
        w = s[15:0];
        if (op == 15) return {w, mkfl(f, f[7], f[6], h, f[2], 1'b0, c)};
        return {w, mkfl(f, w[15], w == 0, h, v, op == 17, c)};
      end
      default: return {a, f};
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual result=%h flags=%h expected result=%h flags=%h",
               tag, act[23:8], act[7:0], exp[23:8], exp[7:0]);
    end
  endtask

  task automatic run_op(input int op, input logic [15:0] a, b, input logic [7:0] f);
    logic [23:0] exp;
    @(negedge clk);
    in_op = op[4:0]; in_a = a; in_b = b; in_flags = f; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    exp = model(op, a, b, f);
    check(out_valid && {out_result, out_flags} == exp, tag_of(op), {out_result, out_flags}, exp);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [23:0] e1, e2;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R12 reset state
    check(!out_valid && in_ready && out_result == 0 && out_flags == 0, "R12",
          {out_result, out_flags}, 24'h0);
    @(negedge clk) rst_n = 1'b1;

    run_op(0, 16'h007F, 16'h0001, 8'h00);   // R3 overflow and half carry
    run_op(1, 16'h00FF, 16'h0000, 8'h01);   // R3 carry in wraps to zero
    run_op(2, 16'h0080, 16'h0001, 8'h00);   // R4 overflow
    run_op(10, 16'h0080, 16'h0000, 8'h00);  // R4 negate of most negative
    run_op(10, 16'h0000, 16'h0000, 8'h01);  // R4 negate zero clears C
    run_op(4, 16'h0042, 16'h0042, 8'h28);   // R5 equal compare
    run_op(5, 16'h00F0, 16'h000F, 8'hFF);   // R6 and to zero
    run_op(8, 16'h00FF, 16'h0000, 8'h01);   // R7 carry kept across wrap
    run_op(9, 16'h0080, 16'h0000, 8'h00);   // R7 decrement overflow
    run_op(14, 16'h0012, 16'h0000, 8'h01);  // R8
    run_op(12, 16'h009A, 16'h0000, 8'h00);  // R9 both corrections
    run_op(12, 16'h000F, 16'h0000, 8'h12);  // R9 after subtraction
    run_op(15, 16'h0FFF, 16'h0001, 8'hC4);  // R10 bit 11 carry
    run_op(17, 16'h8000, 16'h0000, 8'h01);  // R11 overflow on borrow
    run_op(16, 16'hFFFF, 16'h0000, 8'h01);  // R11 wrap to zero
    run_op(25, 16'hBEEF, 16'h1234, 8'hA5);  // R2 unused code

    // R1 back-pressure: first result held, second accepted on drain
    @(negedge clk);
    out_ready = 1'b0;
    in_op = 5'd0; in_a = 16'h0011; in_b = 16'h0022; in_flags = 8'h00; in_valid = 1'b1;
    e1 = model(0, 16'h0011, 16'h0022, 8'h00);
    @(negedge clk);
    in_op = 5'd7; in_a = 16'h00F0; in_b = 16'h00FF; in_flags = 8'h08;
    e2 = model(7, 16'h00F0, 16'h00FF, 8'h08);
    check(!in_ready, "R1", {23'h0, in_ready}, 24'h0);
    @(negedge clk);
    check(out_valid && {out_result, out_flags} == e1, "R1", {out_result, out_flags}, e1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && {out_result, out_flags} == e2, "R1", {out_result, out_flags}, e2);

    for (int i = 0; i < 600; i++) begin
      run_op(int'($urandom % 19), 16'($urandom), 16'($urandom), 8'($urandom));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule